// File: doc/BRIEF.md
# Store Queue with Commit-Gated Writeback

This block holds store operations in program order between dispatch and the data cache. Each store enters at the tail with a sequence number, an address, a data word and a byte size. A store may not leave until the commit stage has passed its sequence number. Once marked, stores are sent one at a time and in order through a request port that can refuse a request. A refused request is held and offered again only when the cache signals a retry.

The cache reports completions by queue index, in any order. Sending a store and freeing its slot are separate steps. A writeback pointer moves over stores as they are sent. The head frees slots only across an unbroken run of completed entries. A squash removes young stores from the tail that have not yet been marked. The block also reports how many new memory operations can be accepted. This is the smaller of its own free count and the free count supplied by the load queue.

Top module: `store_queue_wb`

## Requirements
- R1: After synchronous reset, the head, writeback and tail indices are 0, the store count is 0, `ins_ready` is 1 and `req_valid` is 0.
- R2: The ring has CAPACITY+1 slots, and every index wraps modulo CAPACITY+1. `ins_ready` is 1 exactly when the count is below CAPACITY. An insert writes the slot at the tail index, and the tail moves forward one slot. An insert while the queue is full is ignored.
- R3: A commit with bound B walks from the head toward the tail. Each unmarked store with sequence number at most B is marked. The walk stops at the first unmarked store whose sequence number is above B. A store inserted in the same cycle is not examined.
- R4: A marked store at the writeback index with nonzero size is presented on `req_valid` one cycle after it is marked or reached, with `req_idx` set to its slot. Stores are presented strictly in queue order. Once the request is accepted (`req_valid` and `req_ready` both 1), the writeback index advances one slot.
- R5: A marked store of size 0 raises no request. It is completed and skipped in a single cycle.
- R6: If a request is refused, the queue stalls. While stalled, `req_valid` follows `req_retry`, and the held store is presented unchanged. The stall ends only when a retried request is accepted. No store is ever presented again after it has been accepted.
- R7: While stalled, no later store is presented, and a size-0 store is not skipped.
- R8: `resp_valid` with `resp_idx` marks that slot completed. In the same cycle, the head advances across every consecutive completed entry, stopping at the first incomplete entry or at the tail. The count drops by the number of entries freed.
- R9: A squash with value S removes stores from the tail backward while their sequence number exceeds S. It stops at the first store that is already marked. The tail moves back over the removed entries.
- R10: `free_slots` equals the smaller of `lq_free` and CAPACITY minus the count.
- R11: The head never passes the writeback index, and the writeback index never passes the tail.
- R12: Within one cycle, the commit is applied before the squash, so a store marked in that cycle is protected from it. An insert in a squash cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert a store this cycle |
| ins_seq | input | SEQ_W | Sequence number of the inserted store |
| ins_addr | input | ADDR_W | Store address |
| ins_data | input | DATA_W | Store data |
| ins_size | input | SIZE_W | Store size in bytes, 0 means no data |
| ins_ready | output | 1 | Queue has a free slot |
| commit_valid | input | 1 | Commit bound is valid this cycle |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash this cycle |
| squash_seq | input | SEQ_W | Stores younger than this are squashed |
| req_valid | output | 1 | Cache write request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_retry | input | 1 | Cache invites the held request again |
| req_idx | output | IW | Queue slot of the request |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Request data |
| req_size | output | SIZE_W | Request size |
| resp_valid | input | 1 | A completion arrives |
| resp_idx | input | IW | Slot that completed |
| lq_free | input | CW | Free entries reported by the load queue |
| free_slots | output | CW | Operations that can still be accepted |
| sq_count | output | CW | Stores held |
| head_idx | output | IW | Head slot |
| wb_idx | output | IW | Writeback slot |
| tail_idx | output | IW | Tail slot |

## Verification
The hardest situation to reach is a squash that arrives while the port is stalled on a held store. In that case the walk must stop exactly at the marked entries and leave the held request intact. This only happens when commits, refusals and squashes overlap with the right timing. The bench runs phases with a low acceptance rate and frequent squashes whose bound sits a few numbers below the newest store. It also returns completions in random order so that holes appear in the completed run and hold the head back. A reference model in the bench predicts every output in every cycle.

// File: rtl/sq_pkg.sv
package sq_pkg;
    parameter int unsigned SEQ_W  = 16;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned SIZE_W = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [SIZE_W-1:0] size;
    } sq_pkt_t;

    typedef struct packed {
        logic valid;
        logic can_wb;
        logic sent;
        logic done;
    } sq_flags_t;

    typedef enum logic {WB_OPEN = 1'b0, WB_STALLED = 1'b1} wb_state_e;

    // modular wrap of a possibly negative ring position
    function automatic int ring_wrap(int v, int n);
        int r;
        r = v % n;
        if (r < 0) r = r + n;
        return r;
    endfunction
endpackage

// File: rtl/sq_commit_mark.sv
module sq_commit_mark import sq_pkg::*; #(
    parameter int unsigned SLOTS = 5,
    parameter int unsigned IW    = 3,
    parameter int unsigned CW    = 3
) (
    input  logic [IW-1:0]               head,
    input  logic [CW-1:0]               count,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SLOTS-1:0]            marked,
    input  logic                        commit_valid,
    input  logic [SEQ_W-1:0]            bound,
    output logic [SLOTS-1:0]            mark_vec,
    output logic [CW-1:0]               mark_cnt
);
    // R3: oldest-first walk, halts at first unmarked store beyond the bound
    always_comb begin
        logic stop;
        int   n;
        stop     = 1'b0;
        n        = 0;
        mark_vec = '0;
        for (int k = 0; k < int'(SLOTS); k++) begin
            logic [IW-1:0] idx;
            idx = IW'(ring_wrap(int'(head) + k, int'(SLOTS)));
            if (commit_valid && !stop && k < int'(count) && !marked[idx]) begin
                if (seqs[idx] > bound) begin
                    stop = 1'b1;
                end else begin
                    mark_vec[idx] = 1'b1;
                    n = n + 1;
                end
            end
        end
        mark_cnt = CW'(n);
    end
endmodule

// File: rtl/sq_squash_walk.sv
module sq_squash_walk import sq_pkg::*; #(
    parameter int unsigned SLOTS = 5,
    parameter int unsigned IW    = 3,
    parameter int unsigned CW    = 3
) (
    input  logic [IW-1:0]               tail,
    input  logic [CW-1:0]               count,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seqs,
    input  logic [SLOTS-1:0]            marked,
    input  logic                        squash_valid,
    input  logic [SEQ_W-1:0]            squash_seq,
    output logic [SLOTS-1:0]            kill_vec,
    output logic [CW-1:0]               kill_cnt
);
    // R9: youngest-first walk, halts at a marked store or an old one
    always_comb begin
        logic stop;
        int   n;
        stop     = 1'b0;
        n        = 0;
        kill_vec = '0;
        for (int k = 0; k < int'(SLOTS); k++) begin
            logic [IW-1:0] idx;
            idx = IW'(ring_wrap(int'(tail) - 1 - k, int'(SLOTS)));
            if (squash_valid && !stop && k < int'(count)) begin
                if (marked[idx] || seqs[idx] <= squash_seq) begin
                    stop = 1'b1;
                end else begin
                    kill_vec[idx] = 1'b1;
                    n = n + 1;
                end
            end
        end
        kill_cnt = CW'(n);
    end
endmodule

// File: rtl/sq_head_retire.sv
module sq_head_retire import sq_pkg::*; #(
    parameter int unsigned SLOTS = 5,
    parameter int unsigned IW    = 3,
    parameter int unsigned CW    = 3
) (
    input  logic [IW-1:0]    head,
    input  logic [CW-1:0]    count,
    input  logic [SLOTS-1:0] done_next,
    output logic [SLOTS-1:0] free_vec,
    output logic [CW-1:0]    free_cnt
);
    // R8: free the contiguous completed run starting at the head
    always_comb begin
        logic stop;
        int   n;
        stop     = 1'b0;
        n        = 0;
        free_vec = '0;
        for (int k = 0; k < int'(SLOTS); k++) begin
            logic [IW-1:0] idx;
            idx = IW'(ring_wrap(int'(head) + k, int'(SLOTS)));
            if (!stop && k < int'(count)) begin
                if (done_next[idx]) begin
                    free_vec[idx] = 1'b1;
                    n = n + 1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
        free_cnt = CW'(n);
    end
endmodule

// File: rtl/sq_wb_port.sv
module sq_wb_port import sq_pkg::*; #(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cand_ok,
    input  sq_pkt_t       cand_pkt,
    input  logic [IW-1:0] cand_idx,
    input  logic          req_ready,
    input  logic          req_retry,
    output logic          req_valid,
    output sq_pkt_t       req_pkt,
    output logic [IW-1:0] req_idx,
    output logic          first_try,
    output logic          send_done,
    output logic          stalled
);
    wb_state_e     state_q;
    sq_pkt_t       held_pkt_q;
    logic [IW-1:0] held_idx_q;

    always_comb begin
        if (state_q == WB_OPEN) begin
            req_valid = cand_ok;
            req_pkt   = cand_pkt;
            req_idx   = cand_idx;
        end else begin
            req_valid = req_retry;
            req_pkt   = held_pkt_q;
            req_idx   = held_idx_q;
        end
    end

    assign first_try = (state_q == WB_OPEN) && cand_ok;
    assign send_done = req_valid && req_ready;
    assign stalled   = (state_q == WB_STALLED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WB_OPEN;
            held_pkt_q <= '0;
            held_idx_q <= '0;
        end else if (state_q == WB_OPEN) begin
            if (cand_ok && !req_ready) begin
                state_q    <= WB_STALLED;
                held_pkt_q <= cand_pkt;
                held_idx_q <= cand_idx;
            end
        end else if (req_retry && req_ready) begin
            state_q <= WB_OPEN;
        end
    end

    // R6
    refused_same_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (!req_valid || req_idx == $past(req_idx)));
    // R6
    refused_same_data_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (!req_valid || req_pkt == $past(req_pkt)));
endmodule

// File: rtl/store_queue_wb.sv
module store_queue_wb import sq_pkg::*; #(
    parameter int unsigned CAPACITY = 4,
    parameter int unsigned SLOTS    = CAPACITY + 1,
    parameter int unsigned IW       = $clog2(SLOTS),
    parameter int unsigned CW       = $clog2(CAPACITY + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic [SIZE_W-1:0] ins_size,
    output logic              ins_ready,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              req_valid,
    input  logic              req_ready,
    input  logic              req_retry,
    output logic [IW-1:0]     req_idx,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    output logic [SIZE_W-1:0] req_size,
    input  logic              resp_valid,
    input  logic [IW-1:0]     resp_idx,
    input  logic [CW-1:0]     lq_free,
    output logic [CW-1:0]     free_slots,
    output logic [CW-1:0]     sq_count,
    output logic [IW-1:0]     head_idx,
    output logic [IW-1:0]     wb_idx,
    output logic [IW-1:0]     tail_idx
);
    logic [SLOTS-1:0][SEQ_W-1:0] seq_q;
    sq_pkt_t                     pkt_q [SLOTS];
    sq_flags_t                   flg_q [SLOTS];
    logic [IW-1:0]               head_q, wb_q, tail_q;
    logic [CW-1:0]               count_q, towb_q;

    logic [SLOTS-1:0] marked_now, marked_after, mark_vec, kill_vec, free_vec, done_next;
    logic [CW-1:0]    mark_cnt, kill_cnt, free_cnt;
    logic             wb_has, wb_zero, cand_ok, skip_zero, wb_adv, ins_fire;
    logic             first_try, send_done, stalled;
    sq_pkt_t          req_pkt;
    logic [CW-1:0]    sq_free;

    assign ins_ready = (count_q < CW'(CAPACITY));
    assign ins_fire  = ins_valid && ins_ready && !squash_valid;   // R2, R12

    generate
        for (genvar g = 0; g < int'(SLOTS); g++) begin : g_flag_vec
            assign marked_now[g]   = flg_q[g].can_wb;
            assign marked_after[g] = flg_q[g].can_wb | mark_vec[g];
            assign done_next[g]    = flg_q[g].done
                                   | (resp_valid && resp_idx == IW'(g))
                                   | (skip_zero && wb_q == IW'(g));
        end
    endgenerate

    // R4, R5, R7: eligibility of the store under the writeback pointer
    assign wb_has    = (towb_q != '0) && (wb_q != tail_q) && flg_q[wb_q].valid
                     && flg_q[wb_q].can_wb && !flg_q[wb_q].sent;
    assign wb_zero   = (pkt_q[wb_q].size == '0);
    assign cand_ok   = wb_has && !wb_zero && !stalled;
    assign skip_zero = wb_has && wb_zero && !stalled;
    assign wb_adv    = skip_zero || send_done;

    sq_commit_mark #(.SLOTS(SLOTS), .IW(IW), .CW(CW)) u_mark (
        .head(head_q), .count(count_q), .seqs(seq_q), .marked(marked_now),
        .commit_valid(commit_valid), .bound(commit_seq),
        .mark_vec(mark_vec), .mark_cnt(mark_cnt));

    // R12: squash sees marks made by this cycle's commit
    sq_squash_walk #(.SLOTS(SLOTS), .IW(IW), .CW(CW)) u_squash (
        .tail(tail_q), .count(count_q), .seqs(seq_q), .marked(marked_after),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .kill_vec(kill_vec), .kill_cnt(kill_cnt));

    sq_head_retire #(.SLOTS(SLOTS), .IW(IW), .CW(CW)) u_retire (
        .head(head_q), .count(count_q), .done_next(done_next),
        .free_vec(free_vec), .free_cnt(free_cnt));

    sq_wb_port #(.IW(IW)) u_port (
        .clk(clk), .rst(rst), .cand_ok(cand_ok), .cand_pkt(pkt_q[wb_q]),
        .cand_idx(wb_q), .req_ready(req_ready), .req_retry(req_retry),
        .req_valid(req_valid), .req_pkt(req_pkt), .req_idx(req_idx),
        .first_try(first_try), .send_done(send_done), .stalled(stalled));

    assign req_addr = req_pkt.addr;
    assign req_data = req_pkt.data;
    assign req_size = req_pkt.size;

    // R10
    assign sq_free    = CW'(CAPACITY) - count_q;
    assign free_slots = (lq_free < sq_free) ? lq_free : sq_free;
    assign sq_count   = count_q;
    assign head_idx   = head_q;
    assign wb_idx     = wb_q;
    assign tail_idx   = tail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            wb_q    <= '0;
            tail_q  <= '0;
            count_q <= '0;
            towb_q  <= '0;
            for (int i = 0; i < int'(SLOTS); i++) begin
                flg_q[i] <= '0;
                pkt_q[i] <= '0;
                seq_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(SLOTS); i++) begin
                if (kill_vec[i] || free_vec[i]) begin
                    flg_q[i] <= '0;
                end else begin
                    flg_q[i].can_wb <= marked_after[i];
                    flg_q[i].done   <= done_next[i];
                    if (first_try && wb_q == IW'(i)) flg_q[i].sent <= 1'b1;
                end
            end
            if (ins_fire) begin
                flg_q[tail_q] <= '{valid: 1'b1, can_wb: 1'b0, sent: 1'b0, done: 1'b0};
                seq_q[tail_q] <= ins_seq;
                pkt_q[tail_q] <= '{addr: ins_addr, data: ins_data, size: ins_size};
            end
            head_q  <= IW'(ring_wrap(int'(head_q) + int'(free_cnt), int'(SLOTS)));
            wb_q    <= IW'(ring_wrap(int'(wb_q) + (wb_adv ? 1 : 0), int'(SLOTS)));
            tail_q  <= IW'(ring_wrap(int'(tail_q) - int'(kill_cnt) + (ins_fire ? 1 : 0),
                                     int'(SLOTS)));
            count_q <= count_q - free_cnt - kill_cnt + CW'(ins_fire);
            towb_q  <= towb_q + mark_cnt - CW'(wb_adv);
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(CAPACITY));
    // R11
    head_behind_wb_chk: assert property (@(posedge clk) disable iff (rst)
        ring_wrap(int'(wb_q) - int'(head_q), int'(SLOTS)) <= int'(count_q));
    // R3
    towb_bound_chk: assert property (@(posedge clk) disable iff (rst)
        towb_q <= count_q);
    // R4
    accept_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            int'(wb_q) == ring_wrap(int'($past(req_idx)) + 1, int'(SLOTS)));
    // R9
    squash_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> count_q <= $past(count_q));
endmodule

// File: tb/store_queue_wb_bench.sv
module store_queue_wb_bench;
    import sq_pkg::*;
    localparam int CAP   = 4;
    localparam int SLOTS = CAP + 1;
    localparam int IW    = $clog2(SLOTS);
    localparam int CW    = $clog2(CAP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              ins_valid = 0, commit_valid = 0, squash_valid = 0;
    logic [SEQ_W-1:0]  ins_seq = '0, commit_seq = '0, squash_seq = '0;
    logic [ADDR_W-1:0] ins_addr = '0;
    logic [DATA_W-1:0] ins_data = '0;
    logic [SIZE_W-1:0] ins_size = '0;
    logic              req_ready = 0, req_retry = 0, resp_valid = 0;
    logic [IW-1:0]     resp_idx = '0;
    logic [CW-1:0]     lq_free = '0;
    logic              ins_ready, req_valid;
    logic [IW-1:0]     req_idx, head_idx, wb_idx, tail_idx;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic [SIZE_W-1:0] req_size;
    logic [CW-1:0]     free_slots, sq_count;

    store_queue_wb #(.CAPACITY(CAP)) u_store_queue_wb (.*);

    typedef struct {
        int seq; int addr; int data; int size; int slot;
        bit marked; bit done;
    } ment_t;

    ment_t mq[$];
    int    inflight[$];
    int    m_head, m_wbi, m_towb, next_seq;
    bit    m_blocked;
    int    errors, checks;
    bit    exp_req, exp_skip;

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic compare();
        int len, lqf, sqf, ef;
        len = mq.size();
        exp_req = 0; exp_skip = 0;
        if (!m_blocked) begin
            if (m_towb > 0 && m_wbi < len && mq[m_wbi].marked) begin
                if (mq[m_wbi].size == 0) exp_skip = 1; else exp_req = 1;
            end
        end else begin
            exp_req = req_retry;
        end
        chk(ins_ready == (len < CAP), "R2 ins_ready", int'(ins_ready), int'(len < CAP));
        chk(int'(sq_count) == len, "R8 R9 count", int'(sq_count), len);
        lqf = int'(lq_free); sqf = CAP - len; ef = (lqf < sqf) ? lqf : sqf;
        chk(int'(free_slots) == ef, "R10 free_slots", int'(free_slots), ef);
        chk(int'(head_idx) == m_head, "R8 head_idx", int'(head_idx), m_head);
        chk(int'(wb_idx) == (m_head + m_wbi) % SLOTS, "R4 wb_idx", int'(wb_idx), (m_head + m_wbi) % SLOTS);
        chk(int'(tail_idx) == (m_head + len) % SLOTS, "R2 R9 tail_idx", int'(tail_idx), (m_head + len) % SLOTS);
        chk(req_valid == exp_req, "R3 R4 R5 R6 R7 req_valid", int'(req_valid), int'(exp_req));
        if (exp_req && req_valid) begin
            chk(int'(req_idx) == mq[m_wbi].slot, "R4 req_idx", int'(req_idx), mq[m_wbi].slot);
            chk(req_addr == ADDR_W'(mq[m_wbi].addr), "R4 R6 req_addr", int'(req_addr), mq[m_wbi].addr);
            chk(req_data == DATA_W'(mq[m_wbi].data), "R4 R6 req_data", int'(req_data), mq[m_wbi].data);
            chk(int'(req_size) == mq[m_wbi].size, "R5 req_size", int'(req_size), mq[m_wbi].size);
        end
        ef = (int'(wb_idx) - int'(head_idx) + SLOTS) % SLOTS;
        chk(ef <= int'(sq_count), "R11 head_behind_wb", ef, int'(sq_count));
    endtask

    task automatic model_step();
        int len0;
        bit stop;
        len0 = mq.size();
        // writeback
        if (exp_req && req_ready) begin
            m_blocked = 0;
            inflight.push_back(mq[m_wbi].slot);
            m_wbi++; m_towb--;
        end else if (exp_req && !m_blocked) begin
            m_blocked = 1;
        end else if (exp_skip) begin
            mq[m_wbi].done = 1;
            m_wbi++; m_towb--;
        end
        // completion
        if (resp_valid)
            foreach (mq[i]) if (mq[i].slot == int'(resp_idx)) mq[i].done = 1;
        // commit (before squash, R12)
        if (commit_valid) begin
            stop = 0;
            for (int i = 0; i < len0; i++) begin
                if (!stop && !mq[i].marked) begin
                    if (mq[i].seq > int'(commit_seq)) stop = 1;
                    else begin mq[i].marked = 1; m_towb++; end
                end
            end
        end
        // squash
        if (squash_valid) begin
            while (mq.size() > 0 && mq[$].seq > int'(squash_seq) && !mq[$].marked)
                void'(mq.pop_back());
        end
        // free head run
        while (mq.size() > 0 && mq[0].done) begin
            void'(mq.pop_front());
            m_head = (m_head + 1) % SLOTS;
            m_wbi--;
        end
        // insert
        if (ins_valid && !squash_valid && len0 < CAP) begin
            ment_t e;
            e.seq = int'(ins_seq); e.addr = int'(ins_addr); e.data = int'(ins_data);
            e.size = int'(ins_size); e.slot = (m_head + mq.size()) % SLOTS;
            e.marked = 0; e.done = 0;
            mq.push_back(e);
            next_seq++;
        end
    endtask

    task automatic drive(int p_ins, int p_com, int p_sq, int p_rdy, int p_rty, int p_rsp, int p_zero);
        int r;
        ins_valid    = ($urandom % 100) < p_ins;
        ins_seq      = SEQ_W'(next_seq);
        ins_addr     = ADDR_W'($urandom);
        ins_data     = DATA_W'($urandom);
        ins_size     = (($urandom % 100) < p_zero) ? '0 : SIZE_W'(1 + $urandom % 8);
        commit_valid = ($urandom % 100) < p_com;
        r = next_seq - 1 - int'($urandom % 4);
        commit_seq   = SEQ_W'((r < 0) ? 0 : r);
        squash_valid = ($urandom % 100) < p_sq;
        r = next_seq - 1 - int'($urandom % 5);
        squash_seq   = SEQ_W'((r < 0) ? 0 : r);
        req_ready    = ($urandom % 100) < p_rdy;
        req_retry    = ($urandom % 100) < p_rty;
        lq_free      = CW'($urandom % (CAP + 1));
        resp_valid   = 0;
        if (inflight.size() > 0 && ($urandom % 100) < p_rsp) begin
            int j;
            j = int'($urandom % inflight.size());
            resp_valid = 1;
            resp_idx   = IW'(inflight[j]);
            inflight.delete(j);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        errors = 0; checks = 0;
        m_head = 0; m_wbi = 0; m_towb = 0; next_seq = 1; m_blocked = 0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(sq_count == '0, "R1 count", int'(sq_count), 0);
        chk(ins_ready == 1'b1, "R1 ins_ready", int'(ins_ready), 1);
        chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
        chk(head_idx == '0 && wb_idx == '0 && tail_idx == '0, "R1 pointers",
            int'(head_idx) + int'(wb_idx) + int'(tail_idx), 0);
        @(negedge clk);
        rst = 0;
        for (int ph = 0; ph < 5; ph++) begin
            for (int c = 0; c < 2000; c++) begin
                if (c > 0) @(negedge clk);
                case (ph)
                    0: drive(90, 10, 0, 90, 50, 30, 10);   // fill and full
                    1: drive(60, 40, 5, 70, 50, 50, 15);   // balanced
                    2: drive(60, 40, 25, 20, 30, 40, 10);  // stalls under squash
                    3: drive(70, 50, 5, 60, 40, 60, 60);   // many zero-size stores
                    default: drive(50, 60, 15, 40, 20, 70, 20);
                endcase
                #1;
                compare();
                @(posedge clk);
                model_step();
            end
            @(negedge clk);
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule